// File: doc/BRIEF.md
# MII Receive Deframer

This block sits on the MAC side of a media-independent interface and runs on the receive clock. It takes the 4-bit receive data, the data-valid strobe and the receive-error strobe. It finds the start-of-frame delimiter, discards every preamble nibble, joins nibble pairs into bytes and delivers a byte stream. Start, end and error markers travel with the bytes.

A speed input selects between the two line rates. The rates differ in where data-valid first rises. At 100 Mbit/s it rises on the first preamble nibble, so the block searches through a run of 0x5 nibbles for the 0xD nibble. At 10 Mbit/s it rises on the delimiter itself, so the block expects exactly 0x5 then 0xD. Any other start is dropped silently.

The end of a frame is only known when data-valid falls, so each byte is held back by one byte time. The last byte then leaves with the end marker, which is a single-cycle pulse. The end marker also carries the frame's bad flag and its odd-nibble flag.

Top module: `mii_rx_deframer`

## Requirements
- R1: While reset is low and in the first cycle after it is released, out_valid, out_sof, out_eof, out_bad and out_dribble are all 0.
- R2: Nibbles arrive low half first. Each output byte equals {second nibble, first nibble} of a pair, and pairing starts with the nibble right after the 0xD delimiter nibble.
- R3: With speed_100 = 1, a frame starts when data-valid is high for one or more 0x5 nibbles followed by a 0xD nibble. The number of 0x5 nibbles does not matter.
- R4: With speed_100 = 1, a frame whose first valid nibble is not 0x5, or that has any nibble other than 0x5 or 0xD before the 0xD, produces no output at all.
- R5: With speed_100 = 0, the first two valid nibbles must be 0x5 then 0xD. Any other pair, including 0x5 then 0x5, causes the whole frame to be dropped with no output.
- R6: Nibble values and receive-error while data-valid is low have no effect on the output.
- R7: out_sof marks the first byte and out_eof marks the last byte of a frame. out_eof is a one-cycle pulse that appears one clock after the first clock edge at which data-valid is sampled low.
- R8: If receive-error is high on any data nibble, out_bad is 1 with out_eof. Receive-error on preamble or delimiter nibbles is ignored.
- R9: If data-valid falls after an odd number of data nibbles, out_dribble and out_bad are 1 with out_eof, and the trailing half nibble is discarded.
- R10: A frame with no complete data byte produces no output.
- R11: Frames separated by a single low data-valid cycle are framed independently. The error state of one frame does not reach the next.
- R12: out_bad and out_dribble are only ever 1 together with out_eof. out_sof and out_eof are only ever 1 together with out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100 | input | 1 | 1 selects 100 Mbit/s framing, 0 selects 10 Mbit/s framing |
| rx_dv | input | 1 | Receive data valid |
| rx_d | input | 4 | Receive data nibble |
| rx_er | input | 1 | Receive error |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of a frame |
| out_eof | output | 1 | Last byte of a frame |
| out_bad | output | 1 | Frame had a receive error or odd nibble count (with out_eof) |
| out_dribble | output | 1 | Frame ended on a half byte (with out_eof) |

## Verification
A delimiter hunter left in the wrong state shows up as a whole frame that is missing or spurious. A nibble phase that is off by one shows as bytes with swapped halves starting from the first emitted byte. Both are visible one byte time after the delimiter. An error accumulator that is set wrongly, or not cleared, shows only at out_eof, so each frame is compared record by record, including its flags. The cycle of the end pulse is also checked against the fall of data-valid.

// File: rtl/mii_rx_pkg.sv
`timescale 1ns/1ps
package mii_rx_pkg;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 2 * NIB_W;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_PRE  = 2'd1,
    HS_DATA = 2'd2,
    HS_DROP = 2'd3
  } hunt_st_e;

  // first nibble received is the low half of the byte
  function automatic logic [BYTE_W-1:0] join_nibbles(input logic [NIB_W-1:0] first_nib,
                                                     input logic [NIB_W-1:0] second_nib);
    return {second_nib, first_nib};
  endfunction
endpackage

// File: rtl/mii_rx_sfd_hunt.sv
`timescale 1ns/1ps
module mii_rx_sfd_hunt
  import mii_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             speed_100,
  input  logic             rx_dv,
  input  logic [NIB_W-1:0] rx_d,
  output logic             frame_begin,
  output logic             nib_take,
  output logic             frame_close
);
  hunt_st_e st, nxt;

  always_comb begin
    nxt         = st;
    frame_begin = 1'b0;
    case (st)
      HS_IDLE: if (rx_dv) nxt = (rx_d == PRE_NIB) ? HS_PRE : HS_DROP;
      HS_PRE: begin
        if (!rx_dv) nxt = HS_IDLE;
        else if (rx_d == SFD_NIB) begin
          nxt         = HS_DATA;
          frame_begin = 1'b1;
        end
        else if (rx_d == PRE_NIB && speed_100) nxt = HS_PRE;
        else nxt = HS_DROP;
      end
      HS_DATA: if (!rx_dv) nxt = HS_IDLE;
      HS_DROP: if (!rx_dv) nxt = HS_IDLE;
      default: nxt = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= HS_IDLE;
    else        st <= nxt;
  end

  assign nib_take    = (st == HS_DATA) && rx_dv;
  assign frame_close = (st == HS_DATA) && !rx_dv;

  // R4
  drop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_DROP) |=> (st == HS_DROP || st == HS_IDLE));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_IDLE && !rx_dv) |=> (st == HS_IDLE));

  // R5
  ten_mode_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == HS_PRE && !speed_100 && rx_dv && rx_d == PRE_NIB) |=> (st == HS_DROP));
endmodule

// File: rtl/mii_rx_nibble_pack.sv
`timescale 1ns/1ps
module mii_rx_nibble_pack
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_begin,
  input  logic              nib_take,
  input  logic [NIB_W-1:0]  nib,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              odd_pending
);
  logic             phase;
  logic [NIB_W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= 1'b0;
      lo_q  <= '0;
    end else if (frame_begin) begin
      phase <= 1'b0;
    end else if (nib_take) begin
      phase <= ~phase;
      if (!phase) lo_q <= nib;
    end
  end

  assign byte_done   = nib_take && phase;
  assign byte_val    = join_nibbles(lo_q, nib);
  assign odd_pending = phase;

  // R2
  pair_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !byte_done);
endmodule

// File: rtl/mii_rx_byte_stage.sv
`timescale 1ns/1ps
module mii_rx_byte_stage
  import mii_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_begin,
  input  logic              frame_close,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              odd_pending,
  input  logic              nib_err,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_bad,
  output logic              out_dribble
);
  logic              pend_v, pend_first, got_any, err_acc;
  logic [BYTE_W-1:0] pend_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v <= 1'b0; pend_first <= 1'b0; got_any <= 1'b0; err_acc <= 1'b0;
      pend_b <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0;
      out_eof <= 1'b0; out_bad <= 1'b0; out_dribble <= 1'b0;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      out_bad <= 1'b0; out_dribble <= 1'b0;
      if (frame_begin) begin
        pend_v  <= 1'b0;
        got_any <= 1'b0;
        err_acc <= 1'b0;
      end else begin
        if (nib_err) err_acc <= 1'b1;
        if (byte_done) begin
          if (pend_v) begin
            out_valid <= 1'b1;
            out_data  <= pend_b;
            out_sof   <= pend_first;
          end
          pend_b     <= byte_val;
          pend_v     <= 1'b1;
          pend_first <= !got_any;
          got_any    <= 1'b1;
        end
        if (frame_close) begin
          pend_v <= 1'b0;
          if (pend_v) begin
            out_valid   <= 1'b1;
            out_data    <= pend_b;
            out_sof     <= pend_first;
            out_eof     <= 1'b1;
            out_bad     <= err_acc | odd_pending;
            out_dribble <= odd_pending;
          end
        end
      end
    end
  end

  // R7
  eof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |=> !out_eof);

  // R12
  flag_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_bad || out_dribble) |-> (out_eof && out_valid));

  // R9
  dribble_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dribble |-> out_bad);

  // R7
  mid_byte_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_eof) |-> $past(byte_done));
endmodule

// File: rtl/mii_rx_deframer.sv
`timescale 1ns/1ps
module mii_rx_deframer
  import mii_rx_pkg::*;
#(
  parameter logic [NIB_W-1:0] PRE_NIB = 4'h5,
  parameter logic [NIB_W-1:0] SFD_NIB = 4'hD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              speed_100,
  input  logic              rx_dv,
  input  logic [NIB_W-1:0]  rx_d,
  input  logic              rx_er,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_bad,
  output logic              out_dribble
);
  logic              frame_begin, nib_take, frame_close;
  logic              byte_done, odd_pending, nib_err;
  logic [BYTE_W-1:0] byte_val;

  assign nib_err = nib_take && rx_er;

  mii_rx_sfd_hunt #(.PRE_NIB(PRE_NIB), .SFD_NIB(SFD_NIB)) u_hunt (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rx_dv(rx_dv), .rx_d(rx_d),
    .frame_begin(frame_begin), .nib_take(nib_take), .frame_close(frame_close)
  );

  mii_rx_nibble_pack u_pack (
    .clk(clk), .rst_n(rst_n), .frame_begin(frame_begin), .nib_take(nib_take),
    .nib(rx_d), .byte_done(byte_done), .byte_val(byte_val), .odd_pending(odd_pending)
  );

  mii_rx_byte_stage u_stage (
    .clk(clk), .rst_n(rst_n), .frame_begin(frame_begin), .frame_close(frame_close),
    .byte_done(byte_done), .byte_val(byte_val), .odd_pending(odd_pending),
    .nib_err(nib_err), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_bad(out_bad), .out_dribble(out_dribble)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid);
endmodule

// File: tb/sim_mii_rx_deframer.sv
`timescale 1ns/1ps
module sim_mii_rx_deframer;
  logic       clk = 1'b0, rst_n = 1'b0, speed_100 = 1'b1;
  logic       rx_dv = 1'b0, rx_er = 1'b0;
  logic [3:0] rx_d = 4'h0;
  logic       out_valid, out_sof, out_eof, out_bad, out_dribble;
  logic [7:0] out_data;

  mii_rx_deframer u0 (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .rx_dv(rx_dv), .rx_d(rx_d),
    .rx_er(rx_er), .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
    .out_eof(out_eof), .out_bad(out_bad), .out_dribble(out_dribble)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  // record layout: {sof, eof, bad, dribble, data[7:0]}
  logic [11:0] got[$];
  logic [11:0] exp_q[$];
  int    eof_cyc = -1, exp_fall = 0;
  bit    exp_eof = 1'b0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
    end
  endtask

  // R12: flags never appear without out_valid
  always @(negedge clk) begin
    if (rst_n && (out_sof || out_eof || out_bad || out_dribble))
      chk(out_valid, "R12", "flag without out_valid", 0, 1);
    if (rst_n && out_valid) begin
      got.push_back({out_sof, out_eof, out_bad, out_dribble, out_data});
      if (out_eof) eof_cyc = cyc;
    end
  end

  task automatic drive(input bit dv, input bit er, input logic [3:0] d);
    @(negedge clk);
    rx_dv = dv; rx_er = er; rx_d = d;
  endtask

  task automatic compare_pending();
    int n;
    chk(got.size() == exp_q.size(), cur_tag, "record count", got.size(), exp_q.size());
    n = (got.size() < exp_q.size()) ? got.size() : exp_q.size();
    for (int i = 0; i < n; i++)
      chk(got[i] == exp_q[i], cur_tag, $sformatf("record %0d", i), got[i], exp_q[i]);
    if (exp_eof)
      chk(eof_cyc == exp_fall + 1, "R7", "eof cycle", eof_cyc, exp_fall + 1);
    got.delete(); exp_q.delete(); exp_eof = 1'b0; eof_cyc = -1;
  endtask

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed + i * 53) & 255);
  endfunction

  // mode: 0 good, 1 stray nibble in preamble, 2 no leading 0x5, 3 repeated 0x5 (10 Mbit/s)
  task automatic run_frame(input bit spd, input int mode, input int npre, input int nb,
                           input bit drib, input int erpos, input bit er_pre,
                           input bit noise, input int seed, input string tag);
    logic [5:0] seq[$];
    int  ndat;
    bit  erhit, good;
    ndat = 2 * nb + (drib ? 1 : 0);
    if (noise) begin
      seq.push_back({1'b0, 1'b1, 4'h5});
      seq.push_back({1'b0, 1'b0, 4'hD});
      seq.push_back({1'b0, 1'b1, 4'h3});
    end
    if (mode == 1) begin
      seq.push_back({1'b1, er_pre, 4'h5}); seq.push_back({1'b1, 1'b0, 4'h3});
      seq.push_back({1'b1, 1'b0, 4'h5});
    end else if (mode == 3) begin
      seq.push_back({1'b1, er_pre, 4'h5}); seq.push_back({1'b1, 1'b0, 4'h5});
    end else if (mode == 0) begin
      for (int k = 0; k < (spd ? npre : 1); k++)
        seq.push_back({1'b1, (k == 0) ? er_pre : 1'b0, 4'h5});
    end
    seq.push_back({1'b1, (mode == 2) ? er_pre : 1'b0, 4'hD});
    for (int j = 0; j < ndat; j++) begin
      logic [7:0] b;
      b = pay(seed, j / 2);
      seq.push_back({1'b1, (j == erpos), (j >= 2 * nb) ? 4'hA : ((j % 2) ? b[7:4] : b[3:0])});
    end
    speed_100 = spd;
    foreach (seq[k]) begin
      drive(seq[k][5], seq[k][4], seq[k][3:0]);
      if (k == 0) begin
        #1;
        compare_pending();
        cur_tag = tag;
        good  = (mode == 0);
        erhit = (erpos >= 0) && (erpos < ndat);
        if (good && nb > 0) begin
          for (int i = 0; i < nb; i++)
            exp_q.push_back({(i == 0), (i == nb - 1), (i == nb - 1) && (erhit || drib),
                             (i == nb - 1) && drib, pay(seed, i)});
          exp_eof = 1'b1;
        end
      end
    end
    drive(1'b0, 1'b0, 4'h0);
    exp_fall = cyc;
  endtask

  initial begin
    int seed;
    seed = 8'h5D;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    chk(!(out_valid || out_sof || out_eof || out_bad || out_dribble), "R1", "outputs in reset", 1, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!(out_valid || out_sof || out_eof || out_bad || out_dribble), "R1", "outputs after reset", 1, 0);

    // sweep: speeds, byte counts, odd tail, error position (R2 R5 R3 R8 R9 R10 R6)
    for (int spd = 0; spd < 2; spd++)
      for (int nb = 0; nb < 5; nb++)
        for (int dr = 0; dr < 2; dr++)
          for (int ep = -1; ep < 2 * nb + dr; ep++) begin
            string t;
            if (ep >= 0)         t = "R8";
            else if (nb == 0)    t = "R10";
            else if (dr != 0)    t = "R9";
            else if (spd != 0)   t = "R3";
            else                 t = "R5";
            run_frame(spd[0], 0, 3, nb, dr[0], ep, 1'b0, (ep == -1), seed, {t, " R2 R6"});
            seed = seed + 29;
          end

    // R3: preamble length does not matter
    for (int np = 1; np < 8; np++) begin
      run_frame(1'b1, 0, np, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R3");
      seed = seed + 7;
    end
    // R4: bad starts at 100 Mbit/s
    run_frame(1'b1, 1, 0, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R4");
    run_frame(1'b1, 2, 0, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R4");
    // R5: bad starts at 10 Mbit/s
    run_frame(1'b0, 3, 0, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R5");
    run_frame(1'b0, 2, 0, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R5");
    run_frame(1'b0, 1, 0, 3, 1'b0, -1, 1'b0, 1'b0, seed, "R5");
    // R8: error on preamble nibble ignored
    run_frame(1'b1, 0, 4, 3, 1'b0, -1, 1'b1, 1'b0, seed, "R8");
    run_frame(1'b0, 0, 1, 3, 1'b0, -1, 1'b1, 1'b0, seed, "R8");
    // R11: back-to-back frames, error must not carry over
    run_frame(1'b1, 0, 2, 2, 1'b0, 1, 1'b0, 1'b0, seed + 1, "R11");
    run_frame(1'b1, 0, 2, 2, 1'b0, -1, 1'b0, 1'b0, seed + 2, "R11");
    run_frame(1'b0, 0, 1, 2, 1'b1, -1, 1'b0, 1'b0, seed + 3, "R11");
    run_frame(1'b0, 0, 1, 2, 1'b0, -1, 1'b0, 1'b0, seed + 4, "R11");

    drive(1'b0, 1'b0, 4'h0);
    #1;
    compare_pending();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule